// File: doc/BRIEF.md
# Weighted Replacement Controller with Victim Buffer

This block holds the tag and replacement state of a small fully associative cache with `N_WAYS` entries. Behind the cache sits a victim buffer of `BUF_DEPTH` tags. Each accepted reference reports one of three outcomes. A hit means the tag is in the cache. A partial hit means the tag is in the victim buffer, and the tag moves back into the cache. A miss means the tag is in neither, and the tag is installed in the cache. Only tags and replacement state are modelled. Data arrays, backing-memory timing and energy measurement sit outside the block.

Every cache entry keeps three counters. The recency count R is the number of references since the entry's last use. The gap dT is the recency the entry had at its last hit. The energy sum HE grows by the `hit_energy` input on each hit. When a tag must enter a full cache, the entry with the largest weight R / (HE × dT) is displaced. The block finds that entry with a sequential scan of fixed length and holds `busy` high while the scan runs. The displaced tag is reported on the victim outputs and is pushed into the victim buffer. Once the buffer is full, each new push drops the oldest tag.

Top module: `wrp_ctrl`

## Requirements
- R1: After reset, every cache and buffer slot is empty, `busy` and all result outputs are 0, and the first reference to any tag is a miss without a victim.
- R2: A reference whose tag is in the cache gives `res_hit` in the cycle after acceptance, with no victim. Every other valid entry's R increments. The hit entry's dT takes its R (at least 1), its HE adds `hit_energy`, and its R clears to 0.
- R3: A reference missing the cache while an empty slot exists fills the lowest-index empty slot in the cycle after acceptance, with no victim. The new entry gets R=0, HE=1 and dT=1, and every other valid entry's R increments.
- R4: A reference missing a full cache raises `busy` for `N_WAYS`-1 cycles and gives its result `N_WAYS` cycles after acceptance. The displaced entry is the one with the largest R/(HE×dT), compared as R_a·HE_b·dT_b > R_b·HE_a·dT_a, with ties going to the lowest index. The new tag takes that slot with install values, and all other entries' R increment.
- R5: A displacement raises `victim_valid` with the displaced tag on `victim_tag` for that result cycle, and that tag enters the victim buffer.
- R6: A cache miss whose tag is in the victim buffer reports `res_partial`. The tag is removed from the buffer and installed in the cache as in R3 or R4. An immediate repeat of that tag is a hit.
- R7: When a tag is pushed into a full victim buffer, the oldest buffered tag is dropped, and a later reference to the dropped tag is a miss.
- R8: R, dT and HE saturate at 2^CNT_W-1 instead of wrapping.
- R9: A request raised while `busy` is high is ignored. It produces no result and changes no state.
- R10: A result cycle has `res_valid` high with exactly one of `res_hit`, `res_partial`, `res_miss` set. All of these outputs are 0 in other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Reference request, accepted when `busy` is low |
| req_tag | input | TAG_W | Tag of the reference |
| hit_energy | input | CNT_W | Amount added to HE on a hit (normally 1) |
| busy | output | 1 | Victim scan in progress |
| res_valid | output | 1 | Result cycle |
| res_hit | output | 1 | Outcome: found in cache |
| res_partial | output | 1 | Outcome: found in victim buffer |
| res_miss | output | 1 | Outcome: found nowhere |
| victim_valid | output | 1 | A cache entry was displaced |
| victim_tag | output | TAG_W | Tag of the displaced entry |

## Verification
Results that need no scan (hits and fills into an empty slot) are due at the first sampling point after the accepting edge. A displacement is due at the `N_WAYS`-th sampling point after acceptance. The bench drives at the falling edge and counts falling edges from acceptance until `res_valid` appears. It compares that count with the expected latency as well as the outcome and victim tag. A companion model of the counters, updated from the requirements, predicts every outcome and victim. One reference injected during a scan checks that no extra result follows.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_SCAN = 1'b1} wrp_state_e;
endpackage

// File: rtl/wrp_cam.sv
// Associative tag match; lowest matching index wins.
module wrp_cam #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 8,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]              key,
  output logic                          found,
  output logic [IDX_W-1:0]              idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld[i] && tags[i] == key) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wrp_rank.sv
// Weight comparison without division: a outranks b when
// R_a*HE_b*dT_b > R_b*HE_a*dT_a.
module wrp_rank #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] r_a,
  input  logic [CNT_W-1:0] he_a,
  input  logic [CNT_W-1:0] dt_a,
  input  logic [CNT_W-1:0] r_b,
  input  logic [CNT_W-1:0] he_b,
  input  logic [CNT_W-1:0] dt_b,
  output logic             a_wins
);
  localparam int PW = 3 * CNT_W;
  logic [PW-1:0] lhs, rhs;
  assign lhs    = PW'(r_a) * PW'(he_b) * PW'(dt_b);
  assign rhs    = PW'(r_b) * PW'(he_a) * PW'(dt_a);
  assign a_wins = lhs > rhs;
endmodule

// File: rtl/wrp_vbuf.sv
// Victim buffer kept compacted: slot 0 holds the oldest tag.
module wrp_vbuf #(
  parameter int DEPTH = 2,
  parameter int TAG_W = 8,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] key,
  output logic             found,
  output logic [IDX_W-1:0] found_idx,
  input  logic             rm_en,
  input  logic [IDX_W-1:0] rm_idx,
  input  logic             push_en,
  input  logic [TAG_W-1:0] push_tag
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]            v_q, v_d, tv;
  logic [DEPTH-1:0][TAG_W-1:0] t_q, t_d, tt;
  logic [CW-1:0]               cnt;
  logic                        upd_en;

  wrp_cam #(.ENTRIES(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cam (
    .vld(v_q), .tags(t_q), .key(key), .found(found), .idx(found_idx)
  );

  assign upd_en = rm_en | push_en;

  always_comb begin
    // remove first, closing the gap
    tv = v_q;
    tt = t_q;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (rm_en && i >= int'(rm_idx)) begin
        tv[i] = v_q[i+1];
        tt[i] = t_q[i+1];
      end
    end
    if (rm_en) tv[DEPTH-1] = 1'b0;
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + CW'(tv[i]);
    // then append, dropping the oldest when full
    v_d = tv;
    t_d = tt;
    if (push_en) begin
      if (int'(cnt) < DEPTH) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (CW'(i) == cnt) begin
            v_d[i] = 1'b1;
            t_d[i] = push_tag;
          end
        end
      end else begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          v_d[i] = tv[i+1];
          t_d[i] = tt[i+1];
        end
        v_d[DEPTH-1] = 1'b1;
        t_d[DEPTH-1] = push_tag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      t_q <= '0;
    end else if (upd_en) begin
      v_q <= v_d;
      t_q <= t_d;
    end
  end
endmodule

// File: rtl/wrp_ctrl.sv
module wrp_ctrl
  import wrp_pkg::*;
#(
  parameter int N_WAYS    = 4,
  parameter int BUF_DEPTH = 2,
  parameter int TAG_W     = 8,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [CNT_W-1:0] hit_energy,
  output logic             busy,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_partial,
  output logic             res_miss,
  output logic             victim_valid,
  output logic [TAG_W-1:0] victim_tag
);
  localparam int IDX_W  = (N_WAYS > 1) ? $clog2(N_WAYS) : 1;
  localparam int BIDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  // entry state
  logic [N_WAYS-1:0]            vld_q, vld_d;
  logic [N_WAYS-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [N_WAYS-1:0][CNT_W-1:0] r_q, r_d, he_q, he_d, dt_q, dt_d;
  // control state
  wrp_state_e        st_q, st_d;
  logic [IDX_W-1:0]  best_q, best_d, scan_q, scan_d;
  logic [TAG_W-1:0]  ptag_q, ptag_d;
  logic              ppart_q, ppart_d;
  logic [BIDX_W-1:0] pbidx_q, pbidx_d;
  // result
  logic             rv_d, rh_d, rp_d, rm_d, vv_d;
  logic [TAG_W-1:0] vt_d;

  logic              c_hit, b_hit, f_any, a_wins, accept, upd_en, commit;
  logic [IDX_W-1:0]  c_idx, f_idx, win_idx, tgt;
  logic [BIDX_W-1:0] b_idx, rm_idx;
  logic              rm_en, push_en, do_touch, do_hit, do_install;
  logic [TAG_W-1:0]  push_tag, inst_tag;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] x);
    return (x == CMAX) ? x : x + ONE;
  endfunction

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? CMAX : s[CNT_W-1:0];
  endfunction

  wrp_cam #(.ENTRIES(N_WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cache_cam (
    .vld(vld_q), .tags(tag_q), .key(req_tag), .found(c_hit), .idx(c_idx)
  );

  wrp_vbuf #(.DEPTH(BUF_DEPTH), .TAG_W(TAG_W), .IDX_W(BIDX_W)) u_vbuf (
    .clk(clk), .rst_n(rst_n), .key(req_tag), .found(b_hit), .found_idx(b_idx),
    .rm_en(rm_en), .rm_idx(rm_idx), .push_en(push_en), .push_tag(push_tag)
  );

  wrp_rank #(.CNT_W(CNT_W)) u_rank (
    .r_a(r_q[scan_q]), .he_a(he_q[scan_q]), .dt_a(dt_q[scan_q]),
    .r_b(r_q[best_q]), .he_b(he_q[best_q]), .dt_b(dt_q[best_q]),
    .a_wins(a_wins)
  );

  always_comb begin
    f_any = 1'b0;
    f_idx = '0;
    for (int i = N_WAYS - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        f_any = 1'b1;
        f_idx = IDX_W'(i);
      end
    end
  end

  assign busy    = (st_q == ST_SCAN);
  assign accept  = req_valid && (st_q == ST_IDLE);
  assign commit  = (st_q == ST_SCAN) && (scan_q == IDX_W'(N_WAYS - 1));
  assign win_idx = a_wins ? scan_q : best_q;
  assign upd_en  = accept || (st_q == ST_SCAN);

  // control decisions
  always_comb begin
    st_d = st_q; best_d = best_q; scan_d = scan_q;
    ptag_d = ptag_q; ppart_d = ppart_q; pbidx_d = pbidx_q;
    rv_d = 1'b0; rh_d = 1'b0; rp_d = 1'b0; rm_d = 1'b0;
    vv_d = 1'b0; vt_d = '0;
    rm_en = 1'b0; rm_idx = '0; push_en = 1'b0; push_tag = '0;
    do_touch = 1'b0; do_hit = 1'b0; do_install = 1'b0;
    tgt = '0; inst_tag = req_tag;
    if (accept) begin
      if (c_hit) begin
        rv_d = 1'b1; rh_d = 1'b1;
        do_touch = 1'b1; do_hit = 1'b1; tgt = c_idx;
      end else if (f_any) begin
        rv_d = 1'b1; rp_d = b_hit; rm_d = !b_hit;
        rm_en = b_hit; rm_idx = b_idx;
        do_touch = 1'b1; do_install = 1'b1; tgt = f_idx;
      end else begin
        st_d = ST_SCAN; best_d = '0; scan_d = IDX_W'(1);
        ptag_d = req_tag; ppart_d = b_hit; pbidx_d = b_idx;
      end
    end else if (st_q == ST_SCAN) begin
      if (!commit) begin
        best_d = win_idx;
        scan_d = scan_q + IDX_W'(1);
      end else begin
        st_d = ST_IDLE;
        rv_d = 1'b1; rp_d = ppart_q; rm_d = !ppart_q;
        vv_d = 1'b1; vt_d = tag_q[win_idx];
        rm_en = ppart_q; rm_idx = pbidx_q;
        push_en = 1'b1; push_tag = tag_q[win_idx];
        do_touch = 1'b1; do_install = 1'b1; tgt = win_idx; inst_tag = ptag_q;
      end
    end
  end

  // entry updates
  always_comb begin
    vld_d = vld_q; tag_d = tag_q; r_d = r_q; he_d = he_q; dt_d = dt_q;
    for (int i = 0; i < N_WAYS; i++) begin
      if (do_touch && vld_q[i] && IDX_W'(i) != tgt) r_d[i] = sat_inc(r_q[i]);
    end
    if (do_hit) begin
      dt_d[tgt] = (r_q[tgt] == '0) ? ONE : r_q[tgt];
      he_d[tgt] = sat_add(he_q[tgt], hit_energy);
      r_d[tgt]  = '0;
    end
    if (do_install) begin
      vld_d[tgt] = 1'b1; tag_d[tgt] = inst_tag;
      r_d[tgt] = '0; he_d[tgt] = ONE; dt_d[tgt] = ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0; tag_q <= '0; r_q <= '0; he_q <= '0; dt_q <= '0;
      st_q <= ST_IDLE; best_q <= '0; scan_q <= '0;
      ptag_q <= '0; ppart_q <= 1'b0; pbidx_q <= '0;
      res_valid <= 1'b0; res_hit <= 1'b0; res_partial <= 1'b0;
      res_miss <= 1'b0; victim_valid <= 1'b0; victim_tag <= '0;
    end else begin
      st_q <= st_d; best_q <= best_d; scan_q <= scan_d;
      ptag_q <= ptag_d; ppart_q <= ppart_d; pbidx_q <= pbidx_d;
      res_valid <= rv_d; res_hit <= rh_d; res_partial <= rp_d;
      res_miss <= rm_d; victim_valid <= vv_d; victim_tag <= vt_d;
      if (upd_en) begin
        vld_q <= vld_d; tag_q <= tag_d; r_q <= r_d; he_q <= he_d; dt_q <= dt_d;
      end
    end
  end
endmodule

// File: rtl/wrp_ctrl_chk.sv
module wrp_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic res_valid,
  input logic res_hit,
  input logic res_partial,
  input logic res_miss,
  input logic victim_valid
);
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({res_hit, res_partial, res_miss}) == 1));

  assert_quiet_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ({res_hit, res_partial, res_miss, victim_valid} == 4'b0000));

  assert_hit_keeps_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> !victim_valid);

  assert_scan_ends_in_victim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (res_valid && victim_valid));

  assert_victim_after_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> $past(busy));

  assert_no_result_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !res_valid);
endmodule

bind wrp_ctrl wrp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .res_valid(res_valid),
  .res_hit(res_hit), .res_partial(res_partial), .res_miss(res_miss),
  .victim_valid(victim_valid)
);

// File: tb/sim_wrp_ctrl.sv
module sim_wrp_ctrl;
  localparam int NW = 4, BD = 2, TW = 4, CW = 4, CMX = 15;

  logic clk, rst_n, req_valid;
  logic [TW-1:0] req_tag;
  logic [CW-1:0] hit_energy;
  logic busy, res_valid, res_hit, res_partial, res_miss, victim_valid;
  logic [TW-1:0] victim_tag;

  int total, bad;
  bit done;

  // model of the replacement state
  bit mv[NW];
  int mt[NW], mr[NW], mhe[NW], mdt[NW];
  int bt[BD];
  int bn;

  wrp_ctrl #(.N_WAYS(NW), .BUF_DEPTH(BD), .TAG_W(TW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .hit_energy(hit_energy), .busy(busy), .res_valid(res_valid),
    .res_hit(res_hit), .res_partial(res_partial), .res_miss(res_miss),
    .victim_valid(victim_valid), .victim_tag(victim_tag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sinc(int x);
    return (x >= CMX) ? CMX : x + 1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NW; i++) begin
      mv[i] = 0; mt[i] = 0; mr[i] = 0; mhe[i] = 0; mdt[i] = 0;
    end
    bn = 0;
  endtask

  // kind: 0 hit, 1 partial, 2 miss
  task automatic model_ref(int tag, int e, output int kind, output int vv,
                           output int vt, output int lat);
    int j, k, f, tgt;
    j = -1; vv = 0; vt = 0; lat = 1;
    for (int i = NW - 1; i >= 0; i--) if (mv[i] && mt[i] == tag) j = i;
    if (j >= 0) begin
      kind = 0;
      for (int i = 0; i < NW; i++) if (mv[i] && i != j) mr[i] = sinc(mr[i]);
      mdt[j] = (mr[j] == 0) ? 1 : mr[j];
      mhe[j] = (mhe[j] + e > CMX) ? CMX : mhe[j] + e;
      mr[j] = 0;
    end else begin
      k = -1;
      for (int i = bn - 1; i >= 0; i--) if (bt[i] == tag) k = i;
      kind = (k >= 0) ? 1 : 2;
      if (k >= 0) begin
        for (int i = k; i < bn - 1; i++) bt[i] = bt[i+1];
        bn--;
      end
      f = -1;
      for (int i = NW - 1; i >= 0; i--) if (!mv[i]) f = i;
      if (f >= 0) tgt = f;
      else begin
        tgt = 0;
        for (int i = 1; i < NW; i++)
          if (mr[i] * mhe[tgt] * mdt[tgt] > mr[tgt] * mhe[i] * mdt[i]) tgt = i;
        vv = 1; vt = mt[tgt]; lat = NW;
        if (bn < BD) begin bt[bn] = vt; bn++; end
        else begin
          for (int i = 0; i < BD - 1; i++) bt[i] = bt[i+1];
          bt[BD-1] = vt;
        end
      end
      for (int i = 0; i < NW; i++) if (mv[i] && i != tgt) mr[i] = sinc(mr[i]);
      mv[tgt] = 1; mt[tgt] = tag; mr[tgt] = 0; mhe[tgt] = 1; mdt[tgt] = 1;
    end
  endtask

  // one reference; lbl names an extra requirement for the outcome check
  task automatic do_ref(int tag, int e, string lbl, bit poke);
    int kind, vv, vt, lat, n;
    string rq;
    model_ref(tag, e, kind, vv, vt, lat);
    @(negedge clk);
    req_valid = 1'b1; req_tag = TW'(tag); hit_energy = CW'(e);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    if (poke && busy) begin
      // R9: request during the scan must be ignored
      req_valid = 1'b1; req_tag = TW'(15);
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end
    while (!res_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    rq = (kind == 0) ? "R2" : (kind == 1) ? "R6" : (vv != 0) ? "R4" : "R3";
    chk({rq, " ", lbl}, "outcome hit/partial/miss",
        {29'd0, res_hit, res_partial, res_miss},
        (kind == 0) ? 4 : (kind == 1) ? 2 : 1);
    chk(rq, "latency", n, lat);
    chk("R5", "victim_valid", int'(victim_valid), vv);
    if (vv != 0) chk({"R5 ", lbl}, "victim_tag", int'(victim_tag), vt);
    if (poke) begin
      @(negedge clk);
      chk("R9", "res_valid after ignored request", int'(res_valid), 0);
    end
  endtask

  task automatic do_reset();
    req_valid = 1'b0; req_tag = '0; hit_energy = CW'(1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    do_reset();
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "res_valid after reset", int'(res_valid), 0);
    chk("R1", "victim_valid after reset", int'(victim_valid), 0);

    // fills, hits, displacement, partial hits, buffer overflow
    for (int t = 1; t <= 4; t++) do_ref(t, 1, "R1", 0);
    do_ref(1, 2, "", 0);
    do_ref(2, 1, "", 0);
    do_ref(2, 1, "", 0);
    do_ref(5, 1, "", 1);
    do_ref(3, 1, "R6", 0);
    do_ref(3, 1, "R6", 0);
    do_ref(6, 1, "", 0);
    do_ref(7, 1, "", 0);
    do_ref(8, 1, "", 0);
    do_ref(4, 1, "R7", 0);
    do_ref(15, 1, "R9", 0);

    // saturation: older entries exceed the counter limit
    do_reset();
    for (int t = 1; t <= 4; t++) do_ref(t, 1, "", 0);
    for (int k = 0; k < 14; k++) do_ref(4, 3, "R8", 0);
    do_ref(9, 1, "R8", 0);

    // sweep with a pseudo-random tag stream and varying energy
    do_reset();
    begin
      logic [7:0] lf;
      lf = 8'hA5;
      for (int k = 0; k < 600; k++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        do_ref(int'(lf[2:0]) + ((k % 97 == 0) ? 8 : 0), 1 + (int'(lf[6:5]) % 3),
               "R8", (k % 53) == 7);
      end
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule